// File: doc/BRIEF.md
# Codec Register Command Sequencer

This block runs one register transaction at a time against the audio codecs that share a frame-based serial link. Software loads a 32-bit command word: a read/write flag, a two-bit codec address, a seven-bit register index and sixteen bits of write data. The block then marks the command as outstanding and places it in the command slots of the next link frame. It then counts link frames, or watches the returned status slots, until the transaction is finished.

On completion the outstanding flag drops and a sticky done flag rises. The done flag drives an interrupt unless software masks it. For a read, the value that the codec returns replaces the data field of the command word, and the read/write flag and codec address fields are cleared. Reads may only target codec address 0. A read aimed at any other address is dropped without effect. A codec that never answers a read leaves the command outstanding for good.

Serial bit timing and slot packing belong to a neighbouring block. This block sees only a one-cycle frame-start strobe, the parallel command-slot fields it drives for one frame, and the parallel status-slot fields it receives.

Top module: `codec_cmd_seq`

## Requirements
- R1: After reset, cmd_pending, cmd_done, irq and slot_valid are 0 and cmd_rdata reads 0.
- R2: An accepted command word loads into cmd_rdata and sets cmd_pending one cycle after cmd_wr. The word layout is: bit 25 is the read flag (1 = read), bits 24:23 are the codec address, bits 22:16 are the register index and bits 15:0 are the data. Bits 31:26 read as 0.
- R3: At the first frame_start after acceptance, slot_valid rises. It stays high for exactly one frame, until the next frame_start, and it carries the read flag, codec address, index and data of the command. While slot_valid is 0, the slot fields are 0.
- R4: A write completes at the second frame_start after the frame_start that sent it.
- R5: A read completes in the cycle after a status slot arrives with sts_valid high and sts_index equal to the requested index. The status slot must arrive no earlier than the second frame_start after the send frame started. A status slot that is too early or carries a different index is ignored.
- R6: A read that never gets a matching status slot keeps cmd_pending at 1 and cmd_done at 0 for any number of frames.
- R7: A command with the read flag set and a nonzero codec address is ignored. cmd_pending stays 0, cmd_rdata is unchanged and nothing is sent.
- R8: On completion, cmd_pending clears and cmd_done sets. The read flag and codec address read back 0 and the index is kept. For a read, bits 15:0 hold the returned sts_data. For a write, bits 15:0 keep the written data.
- R9: irq is 1 exactly when cmd_done is 1 and done_mask is 0.
- R10: A done_clr pulse clears cmd_done. If done_clr arrives in the same cycle as a completion, cmd_done ends up set.
- R11: A command word written while cmd_pending is 1 is ignored and leaves cmd_rdata and the transaction in flight unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Command word readback |
| done_clr | input | 1 | Clears the done flag (write-one-to-clear) |
| done_mask | input | 1 | Masks the done interrupt |
| cmd_pending | output | 1 | A command is outstanding |
| cmd_done | output | 1 | Sticky completion flag |
| irq | output | 1 | Completion interrupt |
| frame_start | input | 1 | One-cycle strobe at each link frame start |
| slot_valid | output | 1 | Command slots hold a command this frame |
| slot_rd | output | 1 | Command slot read flag |
| slot_id | output | 2 | Command slot codec address |
| slot_index | output | 7 | Command slot register index |
| slot_data | output | 16 | Command slot write data |
| sts_valid | input | 1 | Status slot carries a returned register value |
| sts_index | input | 7 | Register index in the status slot |
| sts_data | input | 16 | Register value in the status slot |

## Verification
The assertions check the following on every cycle:
- acceptance sets the outstanding flag;
- the slot window opens only on a frame strobe and closes on the next one;
- completion never falls inside the send frame;
- an outstanding command never drops without completing;
- the command register holds still while busy;
- a completion sets the done flag even when a clear arrives with it;
- secondary-codec reads never start a transaction.

Only the bench scenarios show the exact frame count for a write, the rejection of early or mismatched status slots, the data returned by a read, and the interrupt masking.

// File: rtl/ccs_pkg.sv
`timescale 1ns/1ps
package ccs_pkg;
  localparam int WORD_W = 32;
  localparam int ID_W   = 2;
  localparam int IDX_W  = 7;
  localparam int DAT_W  = 16;

  // Packed so that bit 25 = read flag, 24:23 = codec address,
  // 22:16 = register index, 15:0 = data.
  typedef struct packed {
    logic             rd;
    logic [ID_W-1:0]  id;
    logic [IDX_W-1:0] idx;
    logic [DAT_W-1:0] data;
  } cmd_t;

  localparam int CMD_BITS = $bits(cmd_t);
  localparam int RSV_W    = WORD_W - CMD_BITS;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_WAIT   = 2'd1,
    SQ_ACTIVE = 2'd2
  } sq_state_e;

  function automatic cmd_t word_to_cmd(input logic [WORD_W-1:0] w);
    return cmd_t'(w[CMD_BITS-1:0]);
  endfunction

  function automatic logic [WORD_W-1:0] cmd_to_word(input cmd_t c);
    return {{RSV_W{1'b0}}, c};
  endfunction
endpackage

// File: rtl/ccs_rst_sync.sv
`timescale 1ns/1ps
module ccs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/ccs_cmd_reg.sv
`timescale 1ns/1ps
module ccs_cmd_reg
  import ccs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              busy,
  input  logic              complete,
  input  logic [DAT_W-1:0]  rsp_data,
  output cmd_t              cmd,
  output logic              accept
);
  cmd_t incoming;
  cmd_t cmd_d;
  cmd_t cmd_q;
  logic reject_sec;
  logic cmd_en;
  logic unused_rsvd;

  assign unused_rsvd = ^wdata[WORD_W-1:CMD_BITS];

  always_comb begin
    incoming   = word_to_cmd(wdata);
    reject_sec = incoming.rd && (incoming.id != '0);
    accept     = wr && !busy && !reject_sec;
  end

  always_comb begin
    cmd_d = cmd_q;
    if (accept) begin
      cmd_d = incoming;
    end else if (complete) begin
      cmd_d.rd = 1'b0;
      cmd_d.id = '0;
      if (cmd_q.rd) cmd_d.data = rsp_data;
    end
  end

  assign cmd_en = accept | complete;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  assign cmd = cmd_q;

  // R11: the word is frozen while a transaction is in flight
  a_r11_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !complete |=> $stable(cmd_q));

  // R8: completion leaves read flag and codec address at zero
  a_r8_fields_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> (cmd_q.rd == 1'b0) && (cmd_q.id == '0));
endmodule

// File: rtl/ccs_sequencer.sv
`timescale 1ns/1ps
module ccs_sequencer
  import ccs_pkg::*;
#(
  parameter int WR_FRAMES     = 2,
  parameter int RD_MIN_FRAMES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             frame_start,
  input  logic             is_rd,
  input  logic [IDX_W-1:0] idx,
  input  logic             sts_valid,
  input  logic [IDX_W-1:0] sts_index,
  output logic             pending,
  output logic             slot_valid,
  output logic             complete
);
  localparam int MAXF = (RD_MIN_FRAMES > WR_FRAMES) ? RD_MIN_FRAMES : WR_FRAMES;
  localparam int CNT_W = $clog2(MAXF + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAXF);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_FRAMES - 1);
  localparam logic [CNT_W-1:0] RD_OPEN = CNT_W'(RD_MIN_FRAMES);

  sq_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             slot_q, slot_d;
  logic             rsp_hit;

  assign rsp_hit = sts_valid && (sts_index == idx) && (cnt_q >= RD_OPEN);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    slot_d   = slot_q;
    complete = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (accept) state_d = SQ_WAIT;
      end
      SQ_WAIT: begin
        if (frame_start) begin
          state_d = SQ_ACTIVE;
          cnt_d   = '0;
          slot_d  = 1'b1;
        end
      end
      SQ_ACTIVE: begin
        if (frame_start) begin
          slot_d = 1'b0;
          if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
        end
        if (is_rd) complete = rsp_hit;
        else       complete = frame_start && (cnt_q == WR_LAST);
        if (complete) begin
          state_d = SQ_IDLE;
          slot_d  = 1'b0;
        end
      end
      default: begin
        state_d = SQ_IDLE;
        slot_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      slot_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      slot_q  <= slot_d;
    end
  end

  assign pending    = (state_q != SQ_IDLE);
  assign slot_valid = slot_q;

  // R2: accepted command is outstanding on the next cycle
  a_r2_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> pending);

  // R3: slot window opens only on a frame strobe
  a_r3_slot_opens_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_q) |-> $past(frame_start));

  // R3: slot window lasts a single frame
  a_r3_slot_one_frame: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q && frame_start |=> !slot_q);

  // R4: no completion during the frame that carries the command
  a_r4_not_in_send_frame: assert property (@(posedge clk) disable iff (!rst_n)
    complete |-> !slot_q);

  // R6: outstanding flag only drops through a completion
  a_r6_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !complete |=> pending);
endmodule

// File: rtl/ccs_event.sv
`timescale 1ns/1ps
module ccs_event (
  input  logic clk,
  input  logic rst_n,
  input  logic complete,
  input  logic clr,
  input  logic mask,
  output logic done,
  output logic irq
);
  logic done_q, done_d, done_en;

  assign done_en = complete | clr;
  assign done_d  = complete;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_q <= 1'b0;
    else if (done_en) done_q <= done_d;
  end

  assign done = done_q;
  assign irq  = done_q & ~mask;

  // R10: a completion always leaves the flag set, clear or not
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> done_q);

  // R10: a lone clear empties the flag
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !complete |=> !done_q);
endmodule

// File: rtl/codec_cmd_seq.sv
`timescale 1ns/1ps
module codec_cmd_seq
  import ccs_pkg::*;
#(
  parameter int WR_FRAMES     = 2,
  parameter int RD_MIN_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic [WORD_W-1:0] cmd_rdata,
  input  logic              done_clr,
  input  logic              done_mask,
  output logic              cmd_pending,
  output logic              cmd_done,
  output logic              irq,
  input  logic              frame_start,
  output logic              slot_valid,
  output logic              slot_rd,
  output logic [ID_W-1:0]   slot_id,
  output logic [IDX_W-1:0]  slot_index,
  output logic [DAT_W-1:0]  slot_data,
  input  logic              sts_valid,
  input  logic [IDX_W-1:0]  sts_index,
  input  logic [DAT_W-1:0]  sts_data
);
  logic rst_n_s;
  cmd_t cmd;
  logic accept;
  logic complete;
  logic pending;
  logic slot_q;

  ccs_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  ccs_cmd_reg u_cmd (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr       (cmd_wr),
    .wdata    (cmd_wdata),
    .busy     (pending),
    .complete (complete),
    .rsp_data (sts_data),
    .cmd      (cmd),
    .accept   (accept)
  );

  ccs_sequencer #(
    .WR_FRAMES     (WR_FRAMES),
    .RD_MIN_FRAMES (RD_MIN_FRAMES)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .accept      (accept),
    .frame_start (frame_start),
    .is_rd       (cmd.rd),
    .idx         (cmd.idx),
    .sts_valid   (sts_valid),
    .sts_index   (sts_index),
    .pending     (pending),
    .slot_valid  (slot_q),
    .complete    (complete)
  );

  ccs_event u_evt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .complete (complete),
    .clr      (done_clr),
    .mask     (done_mask),
    .done     (cmd_done),
    .irq      (irq)
  );

  always_comb begin
    slot_valid = slot_q;
    slot_rd    = slot_q & cmd.rd;
    slot_id    = slot_q ? cmd.id   : '0;
    slot_index = slot_q ? cmd.idx  : '0;
    slot_data  = slot_q ? cmd.data : '0;
  end

  assign cmd_pending = pending;
  assign cmd_rdata   = cmd_to_word(cmd);

  // R7: a read to a secondary codec never starts a transaction
  a_r7_secondary_read: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmd_wr && !cmd_pending && cmd_wdata[25] && (cmd_wdata[24:23] != 2'b00)
      |=> !cmd_pending && $stable(cmd_rdata));
endmodule

// File: tb/codec_cmd_seq_tb.sv
`timescale 1ns/1ps
module codec_cmd_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_wr;
  logic [31:0] cmd_wdata;
  logic [31:0] cmd_rdata;
  logic        done_clr, done_mask;
  logic        cmd_pending, cmd_done, irq;
  logic        frame_start;
  logic        slot_valid, slot_rd;
  logic [1:0]  slot_id;
  logic [6:0]  slot_index;
  logic [15:0] slot_data;
  logic        sts_valid;
  logic [6:0]  sts_index;
  logic [15:0] sts_data;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  codec_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .done_clr(done_clr), .done_mask(done_mask),
    .cmd_pending(cmd_pending), .cmd_done(cmd_done), .irq(irq),
    .frame_start(frame_start), .slot_valid(slot_valid), .slot_rd(slot_rd),
    .slot_id(slot_id), .slot_index(slot_index), .slot_data(slot_data),
    .sts_valid(sts_valid), .sts_index(sts_index), .sts_data(sts_data)
  );

  function automatic logic [31:0] word(input logic rd, input logic [1:0] id,
                                       input logic [6:0] idx, input logic [15:0] d);
    return {6'b0, rd, id, idx, d};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_cmd(input logic rd, input logic [1:0] id,
                         input logic [6:0] idx, input logic [15:0] d);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = word(rd, id, idx, d) | 32'hFC00_0000;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_wdata = '0;
  endtask

  task automatic frame(input logic with_clr = 1'b0);
    @(negedge clk);
    frame_start = 1'b1; done_clr = with_clr;
    @(negedge clk);
    frame_start = 1'b0; done_clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic status(input logic [6:0] idx, input logic [15:0] d);
    @(negedge clk);
    sts_valid = 1'b1; sts_index = idx; sts_data = d;
    @(negedge clk);
    sts_valid = 1'b0; sts_index = '0; sts_data = '0;
  endtask

  task automatic clear_done();
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  function automatic logic [31:0] slots();
    return {5'b0, slot_valid, slot_rd, slot_id, slot_index, slot_data};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    rst_n = 1'b0; cmd_wr = 0; cmd_wdata = 0; done_clr = 0; done_mask = 0;
    frame_start = 0; sts_valid = 0; sts_index = 0; sts_data = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values
    chk("R1 pending", {31'b0, cmd_pending}, 0);
    chk("R1 done", {31'b0, cmd_done}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 slot", slots(), 0);
    chk("R1 rdata", cmd_rdata, 0);

    // Write sweep over every codec address
    for (int id = 0; id < 4; id++) begin
      logic [6:0]  ix;
      logic [15:0] dv;
      ix = 7'(id * 37 + 5);
      dv = 16'hA500 ^ 16'(id * 16'h1111);
      put_cmd(1'b0, 2'(id), ix, dv);
      chk("R2 pending set", {31'b0, cmd_pending}, 1);
      chk("R2 readback layout", cmd_rdata, word(1'b0, 2'(id), ix, dv));
      chk("R3 no slot before frame", slots(), 0);
      frame();
      chk("R3 slot carries write", slots(), {5'b0, 1'b1, 1'b0, 2'(id), ix, dv});
      frame();
      chk("R3 slot closed", {31'b0, slot_valid}, 0);
      chk("R4 still pending after one frame", {30'b0, cmd_pending, cmd_done}, 32'h2);
      frame();
      chk("R4 write completes", {30'b0, cmd_pending, cmd_done}, 32'h1);
      chk("R8 write readback", cmd_rdata, word(1'b0, 2'b0, ix, dv));
      chk("R9 irq unmasked", {31'b0, irq}, 1);
      clear_done();
      chk("R10 cleared", {30'b0, cmd_done, irq}, 0);
    end

    // R7: secondary codec reads dropped
    held = cmd_rdata;
    for (int id = 1; id < 4; id++) begin
      put_cmd(1'b1, 2'(id), 7'h12, 16'h0);
      chk("R7 not pending", {31'b0, cmd_pending}, 0);
      chk("R7 rdata kept", cmd_rdata, held);
      frame();
      chk("R7 nothing sent", slots(), 0);
    end

    // Reads from codec 0, with early and mismatched status slots
    for (int k = 0; k < 3; k++) begin
      logic [6:0]  ix;
      logic [15:0] rv;
      ix = 7'(k * 41 + 3);
      rv = 16'h5A00 + 16'(k * 16'h0123);
      done_mask = (k == 1);
      put_cmd(1'b1, 2'b0, ix, 16'h0);
      chk("R2 read readback", cmd_rdata, word(1'b1, 2'b0, ix, 16'h0));
      frame();
      chk("R3 slot carries read", slots(), {5'b0, 1'b1, 1'b1, 2'b0, ix, 16'h0});
      status(ix, 16'hDEAD);
      chk("R5 early status ignored (send frame)", {30'b0, cmd_pending, cmd_done}, 32'h2);
      frame();
      status(ix, 16'hBEEF);
      chk("R5 early status ignored (frame 2)", {30'b0, cmd_pending, cmd_done}, 32'h2);
      frame();
      status(ix ^ 7'h1, 16'h1234);
      chk("R5 mismatched index ignored", {30'b0, cmd_pending, cmd_done}, 32'h2);
      status(ix, rv);
      chk("R5 read completes", {30'b0, cmd_pending, cmd_done}, 32'h1);
      chk("R8 read data returned", cmd_rdata, word(1'b0, 2'b0, ix, rv));
      chk("R9 irq vs mask", {31'b0, irq}, (k == 1) ? 0 : 1);
      done_mask = 1'b0;
      @(negedge clk);
      chk("R9 irq after unmask", {31'b0, irq}, 1);
      clear_done();
    end

    // R10: clear in the completing cycle loses to the completion
    put_cmd(1'b0, 2'd1, 7'h33, 16'h0F0F);
    frame(); frame();
    frame(1'b1);
    chk("R10 set wins over clear", {30'b0, cmd_pending, cmd_done}, 32'h1);
    clear_done();
    chk("R10 clear after", {31'b0, cmd_done}, 0);

    // R11: second command while pending is dropped
    put_cmd(1'b0, 2'd1, 7'h21, 16'hAAAA);
    put_cmd(1'b0, 2'd2, 7'h44, 16'h5555);
    chk("R11 first command kept", cmd_rdata, word(1'b0, 2'd1, 7'h21, 16'hAAAA));
    frame();
    chk("R11 first command sent", slots(), {5'b0, 1'b1, 1'b0, 2'd1, 7'h21, 16'hAAAA});
    frame(); frame();
    chk("R11 first command finished", cmd_rdata, word(1'b0, 2'd0, 7'h21, 16'hAAAA));
    clear_done();

    // R6: read with no answer stays outstanding
    put_cmd(1'b1, 2'b0, 7'h09, 16'h0);
    for (int f = 0; f < 10; f++) begin
      frame();
      status(7'h0A, 16'h7777);
    end
    chk("R6 still pending", {30'b0, cmd_pending, cmd_done}, 32'h2);
    put_cmd(1'b0, 2'd3, 7'h01, 16'h1111);
    chk("R11 ignored during stuck read", cmd_rdata, word(1'b1, 2'b0, 7'h09, 16'h0));
    chk("R6 irq stays low", {31'b0, irq}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule